// File: doc/BRIEF.md
# NAND Register-Indirect Bus Sequencer

This block lets a processor drive an 8-bit NAND flash device through a small set of registers. Software first writes a mode code that picks what the next bytes mean: commands, address bytes or page data. It then reads or writes the data register. Each data-register access becomes exactly one external read or write strobe cycle. The strobe low time comes from a programmable pulse-width register, and the high time that follows is one clock. The host acknowledge of a data access is held back until that external cycle has fully ended.

A sampled ready/busy input raises a sticky status flag on each rising edge. Software clears the flag by writing a 1 to it. An interrupt-mask register decides whether the flag reaches the interrupt output. A bus-separate bit in the mode register drives an active-low indicator output. In data mode every transferred byte is also handed to an external ECC engine as a one-clock valid pulse that carries the byte value. There is no write-protect output; external logic keeps that pin inactive.

Top module: `nfc_regseq`

## Requirements
- R1: After reset, all strobes, latch enables and the bus-separate indicator are high (inactive), `hready`, `irq` and `ecc_vld` are low, and mode, mask and pulse-width registers read 0.
- R2: With mode code 0x91 (ignoring bit 3), `nd_cle_n` is low for every cycle of a data-register write strobe cycle (low phase plus high phase) and `nd_ale_n` stays high. In this mode `nd_cle_n` stays high on reads.
- R3: With mode code 0x92 (ignoring bit 3), `nd_ale_n` is low for every cycle of a data-register write strobe cycle and `nd_cle_n` stays high. In this mode `nd_ale_n` stays high on reads.
- R4: With mode code 0xB0 (ignoring bit 3), neither latch enable is asserted. Every data-register access gives exactly one `ecc_vld` pulse, with `ecc_byte` equal to the written byte or to the byte read. In any other mode no `ecc_vld` pulse occurs.
- R5: A data-register access drives its strobe (`nd_we_n` for a write, `nd_re_n` for a read) low for max(P,1) clocks, where P is the pulse-width register (offset 0x14). A high clock follows. `hready` is then seen max(P,1)+2 clocks after the request is first sampled. The two strobes are never low together.
- R6: A data-register read returns on `hrdata` the `nd_din` value present in the last low clock of `nd_re_n`.
- R7: Writes to the mode (0x04), interrupt-mask (0x10) and pulse-width (0x14) registers are acknowledged one clock after the request and read back unchanged. `hready` lasts one clock.
- R8: Bit 3 of the mode register drives `nd_bsep_n` low. The mode decode of R2 to R4 ignores that bit.
- R9: A rising edge on `nd_rdy` sets bit 0 of the status register (offset 0x08). Writing 1 to that bit clears it. If a set and a clear land on the same clock, the flag ends set.
- R10: `irq` is high only while the status flag is set and the interrupt-mask register has both bit 7 and bit 0 set (value 0x81).
- R11: During a write strobe cycle `nd_doe` is high and `nd_dout` carries the written byte. On reads `nd_doe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsel | input | 1 | Host request valid, held until `hready` |
| hwr | input | 1 | Host write |
| hrd | input | 1 | Host read |
| haddr | input | AW | Register byte offset |
| hwdata | input | 8 | Host write data |
| hrdata | output | 8 | Host read data, valid with `hready` |
| hready | output | 1 | One-clock acknowledge |
| irq | output | 1 | Interrupt request |
| nd_cle_n | output | 1 | Command latch enable, active low |
| nd_ale_n | output | 1 | Address latch enable, active low |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_dout | output | 8 | Data to flash |
| nd_doe | output | 1 | Data output enable |
| nd_din | input | 8 | Data from flash |
| nd_rdy | input | 1 | Ready/busy from flash |
| nd_bsep_n | output | 1 | Bus-separate indicator, active low |
| ecc_vld | output | 1 | One-clock byte-valid pulse to ECC engine |
| ecc_byte | output | 8 | Byte transferred in data mode |

## Verification
A rising edge on the ready input and a software write-one-clear of the status flag can commit on the same clock edge. The bench raises `nd_rdy` and then issues the status write with the commit edge placed one clock before, exactly on, and one clock after the clock where the synchronised edge sets the flag. It then reads the flag back: it must be set, set and clear respectively, because set wins a tie. The mode and pulse-width sweep also checks that ECC pulses and latch enables never appear outside their mode, whatever strobe length is in use.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   localparam int DATA_W   = 8;
   localparam int BSEP_BIT = 3;

   localparam logic [DATA_W-1:0] CODE_CMD = 8'h91;
   localparam logic [DATA_W-1:0] CODE_ADR = 8'h92;
   localparam logic [DATA_W-1:0] CODE_DAT = 8'hB0;

   localparam int OFS_DATA  = 'h00;
   localparam int OFS_MODE  = 'h04;
   localparam int OFS_STAT  = 'h08;
   localparam int OFS_IMASK = 'h10;
   localparam int OFS_PULSE = 'h14;

   typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} strobe_st_t;
   typedef enum logic [1:0] {LANE_NONE, LANE_CMD, LANE_ADR, LANE_DAT} lane_t;

   function automatic lane_t lane_of(input logic [DATA_W-1:0] code);
      logic [DATA_W-1:0] core;
      core = code & ~(DATA_W'(1) << BSEP_BIT);
      if (core == CODE_CMD)      return LANE_CMD;
      else if (core == CODE_ADR) return LANE_ADR;
      else if (core == CODE_DAT) return LANE_DAT;
      return LANE_NONE;
   endfunction
endpackage

// File: rtl/nfc_regs.sv
module nfc_regs
   import nfc_pkg::*;
#(
   parameter int AW          = 5,
   parameter int PW_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              nd_rdy,
   output logic [DATA_W-1:0] mode,
   output logic [PW_W-1:0]   pulse_w,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (PW_W < 1 || PW_W > DATA_W) begin : g_bad_pw
         $error("PW_W must lie between 1 and DATA_W");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;
   logic                   stat_q;
   logic [DATA_W-1:0]      imask_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= nd_rdy;
         end
      end else begin : g_syncn
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], nd_rdy};
         end
      end
   endgenerate

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         stat_q  <= 1'b0;
         mode    <= '0;
         imask_q <= '0;
         pulse_w <= '0;
      end else begin
         prev_q <= sync_q[SYNC_STAGES-1];
         if (rise)
            stat_q <= 1'b1;
         else if (wr_en && addr == AW'(OFS_STAT) && wdata[0])
            stat_q <= 1'b0;
         if (wr_en && addr == AW'(OFS_MODE))  mode    <= wdata;
         if (wr_en && addr == AW'(OFS_IMASK)) imask_q <= wdata;
         if (wr_en && addr == AW'(OFS_PULSE)) pulse_w <= wdata[PW_W-1:0];
      end
   end

   always_comb begin
      case (addr)
         AW'(OFS_MODE):  rdata = mode;
         AW'(OFS_STAT):  rdata = {{(DATA_W-1){1'b0}}, stat_q};
         AW'(OFS_IMASK): rdata = imask_q;
         AW'(OFS_PULSE): rdata = DATA_W'(pulse_w);
         default:        rdata = '0;
      endcase
   end

   assign irq = stat_q & imask_q[DATA_W-1] & imask_q[0];

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> stat_q);
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe
   import nfc_pkg::*;
#(
   parameter int PW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_wr,
   input  logic [DATA_W-1:0] wbyte,
   input  logic [PW_W-1:0]   pulse_w,
   input  logic [DATA_W-1:0] nd_din,
   output logic              busy,
   output logic              is_wr,
   output logic              sample,
   output logic              finish,
   output logic [DATA_W-1:0] dout,
   output logic [DATA_W-1:0] rbyte,
   output logic              we_n,
   output logic              re_n,
   output logic              doe
);
   strobe_st_t      st_q;
   logic [PW_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         is_wr <= 1'b0;
         dout  <= '0;
         rbyte <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               st_q  <= ST_LOW;
               cnt_q <= (pulse_w == '0) ? '0 : pulse_w - PW_W'(1);
               is_wr <= start_wr;
               dout  <= wbyte;
            end
            ST_LOW: if (cnt_q == '0) begin
               st_q  <= ST_HIGH;
               rbyte <= nd_din;
            end else begin
               cnt_q <= cnt_q - PW_W'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (st_q != ST_IDLE);
   assign sample = (st_q == ST_LOW) && (cnt_q == '0);
   assign finish = (st_q == ST_HIGH);
   assign we_n   = !((st_q == ST_LOW) && is_wr);
   assign re_n   = !((st_q == ST_LOW) && !is_wr);
   assign doe    = busy && is_wr;

   assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   assert_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> doe);
   assert_high_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      finish |-> $past(sample));
endmodule

// File: rtl/nfc_regseq.sv
module nfc_regseq
   import nfc_pkg::*;
#(
   parameter int AW          = 5,
   parameter int PW_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsel,
   input  logic              hwr,
   input  logic              hrd,
   input  logic [AW-1:0]     haddr,
   input  logic [7:0]        hwdata,
   output logic [7:0]        hrdata,
   output logic              hready,
   output logic              irq,
   output logic              nd_cle_n,
   output logic              nd_ale_n,
   output logic              nd_we_n,
   output logic              nd_re_n,
   output logic [7:0]        nd_dout,
   output logic              nd_doe,
   input  logic [7:0]        nd_din,
   input  logic              nd_rdy,
   output logic              nd_bsep_n,
   output logic              ecc_vld,
   output logic [7:0]        ecc_byte
);
   generate
      if (AW < 5) begin : g_bad_aw
         $error("AW must reach offset 0x14");
      end
   endgenerate

   logic              req, idle_ok, dat_hit, start_dat, start_reg;
   logic              s_busy, s_wr, s_sample, s_finish;
   logic [DATA_W-1:0] s_dout, s_rbyte, mode, reg_rdata;
   logic [PW_W-1:0]   pulse_w;
   logic              ack_q, dat_ack_q;
   lane_t             lane;

   assign req       = hsel && (hwr || hrd);
   assign idle_ok   = !ack_q && !s_busy;
   assign dat_hit   = (haddr == AW'(OFS_DATA));
   assign start_dat = req && idle_ok && dat_hit;
   assign start_reg = req && idle_ok && !dat_hit;

   nfc_regs #(.AW(AW), .PW_W(PW_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(start_reg && hwr), .addr(haddr),
      .wdata(hwdata), .nd_rdy(nd_rdy), .mode(mode), .pulse_w(pulse_w),
      .rdata(reg_rdata), .irq(irq)
   );

   nfc_strobe #(.PW_W(PW_W)) u_strobe (
      .clk(clk), .rst_n(rst_n), .start(start_dat), .start_wr(hwr),
      .wbyte(hwdata), .pulse_w(pulse_w), .nd_din(nd_din), .busy(s_busy),
      .is_wr(s_wr), .sample(s_sample), .finish(s_finish), .dout(s_dout),
      .rbyte(s_rbyte), .we_n(nd_we_n), .re_n(nd_re_n), .doe(nd_doe)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q     <= 1'b0;
         dat_ack_q <= 1'b0;
         hrdata    <= '0;
         ecc_vld   <= 1'b0;
         ecc_byte  <= '0;
      end else begin
         ack_q     <= start_reg || s_finish;
         dat_ack_q <= s_finish;
         if (start_reg && hrd)       hrdata <= reg_rdata;
         else if (s_finish && !s_wr) hrdata <= s_rbyte;
         ecc_vld <= s_sample && (lane == LANE_DAT);
         if (s_sample && lane == LANE_DAT)
            ecc_byte <= s_wr ? s_dout : nd_din;
      end
   end

   assign lane      = lane_of(mode);
   assign hready    = ack_q;
   assign nd_dout   = s_dout;
   assign nd_cle_n  = !(s_busy && s_wr && lane == LANE_CMD);
   assign nd_ale_n  = !(s_busy && s_wr && lane == LANE_ADR);
   assign nd_bsep_n = !mode[BSEP_BIT];

   assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nd_cle_n && !nd_ale_n));
   assert_ecc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_vld |=> !ecc_vld);
   assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hready |=> !hready);
   assert_ack_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && dat_ack_q) |-> $past(nd_we_n && nd_re_n));
endmodule

// File: tb/nfc_regseq_tb.sv
module nfc_regseq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hsel = 0, hwr = 0, hrd = 0, nd_rdy = 0;
   logic [AW-1:0] haddr = '0;
   logic [7:0] hwdata = '0, nd_din = '0, hrdata, nd_dout, ecc_byte;
   logic hready, irq, nd_cle_n, nd_ale_n, nd_we_n, nd_re_n, nd_doe, nd_bsep_n, ecc_vld;

   int checks = 0, errors = 0;
   int we_low, re_low, cle_low, ale_low, doe_hi, dout_bad, ecc_cnt;
   logic [7:0] ecc_last, exp_dout;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nfc_regseq #(.AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .hsel(hsel), .hwr(hwr), .hrd(hrd), .haddr(haddr),
      .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .irq(irq),
      .nd_cle_n(nd_cle_n), .nd_ale_n(nd_ale_n), .nd_we_n(nd_we_n), .nd_re_n(nd_re_n),
      .nd_dout(nd_dout), .nd_doe(nd_doe), .nd_din(nd_din), .nd_rdy(nd_rdy),
      .nd_bsep_n(nd_bsep_n), .ecc_vld(ecc_vld), .ecc_byte(ecc_byte)
   );

   always @(negedge clk) begin
      if (!nd_we_n) we_low++;
      if (!nd_re_n) re_low++;
      if (!nd_cle_n) cle_low++;
      if (!nd_ale_n) ale_low++;
      if (nd_doe) doe_hi++;
      if (!nd_we_n && nd_dout !== exp_dout) dout_bad++;
      if (ecc_vld) begin ecc_cnt++; ecc_last = ecc_byte; end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr_mon();
      we_low = 0; re_low = 0; cle_low = 0; ale_low = 0;
      doe_hi = 0; dout_bad = 0; ecc_cnt = 0; ecc_last = 'x;
   endtask

   // called at a falling edge; returns at a falling edge after one idle clock
   task automatic hostop(input logic [AW-1:0] a, input bit w, input logic [7:0] d,
                         output logic [7:0] rd, output int cyc);
      hsel = 1; hwr = w; hrd = !w; haddr = a; hwdata = d; cyc = 0;
      do begin @(posedge clk); cyc++; @(negedge clk); end while (!hready && cyc < 100);
      rd = hrdata;
      hsel = 0; hwr = 0; hrd = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd, m, wd;
      logic [7:0] modes [4];
      int cyc, len;
      modes = '{8'h91, 8'h92, 8'hB0, 8'h41};
      clr_mon();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(nd_we_n && nd_re_n && nd_cle_n && nd_ale_n && nd_bsep_n, "R1 strobes idle", 0, 1);
      chk(!hready && !irq && !ecc_vld, "R1 ack/irq/ecc low", int'(hready), 0);
      hostop(5'h04, 0, 0, rd, cyc); chk(rd == 0, "R1 mode reset", rd, 0);
      hostop(5'h14, 0, 0, rd, cyc); chk(rd == 0, "R1 pulse reset", rd, 0);
      hostop(5'h10, 0, 0, rd, cyc); chk(rd == 0, "R1 mask reset", rd, 0);

      // R7 register writes and readback
      hostop(5'h10, 1, 8'h81, rd, cyc); chk(cyc == 1, "R7 reg ack latency", cyc, 1);
      hostop(5'h10, 0, 0, rd, cyc);     chk(rd == 8'h81, "R7 mask readback", rd, 8'h81);
      hostop(5'h14, 1, 8'h03, rd, cyc);
      hostop(5'h14, 0, 0, rd, cyc);     chk(rd == 8'h03, "R7 pulse readback", rd, 3);

      // sweep: R2 R3 R4 R5 R6 R11
      for (int mi = 0; mi < 4; mi++) begin
         m = modes[mi];
         hostop(5'h04, 1, m, rd, cyc);
         chk(nd_bsep_n == 1'b1, "R8 bsep off", int'(nd_bsep_n), 1);
         for (int pw = 0; pw < 6; pw++) begin
            hostop(5'h14, 1, 8'(pw), rd, cyc);
            len = (pw == 0) ? 1 : pw;
            for (int w = 0; w < 2; w++) begin
               wd = 8'(pw * 37 + int'(m) + w);
               nd_din = ~wd;
               exp_dout = wd;
               clr_mon();
               hostop(5'h00, w[0], wd, rd, cyc);
               chk(cyc == len + 2, "R5 ack latency", cyc, len + 2);
               chk(we_low == (w ? len : 0), "R5 we low width", we_low, w ? len : 0);
               chk(re_low == (w ? 0 : len), "R5 re low width", re_low, w ? 0 : len);
               chk(cle_low == ((m == 8'h91 && w) ? len + 1 : 0), "R2 cle", cle_low,
                   (m == 8'h91 && w) ? len + 1 : 0);
               chk(ale_low == ((m == 8'h92 && w) ? len + 1 : 0), "R3 ale", ale_low,
                   (m == 8'h92 && w) ? len + 1 : 0);
               chk(ecc_cnt == ((m == 8'hB0) ? 1 : 0), "R4 ecc count", ecc_cnt,
                   (m == 8'hB0) ? 1 : 0);
               if (m == 8'hB0)
                  chk(ecc_last == (w ? wd : ~wd), "R4 ecc byte", ecc_last, w ? wd : ~wd);
               chk(doe_hi == (w ? len + 1 : 0), "R11 doe", doe_hi, w ? len + 1 : 0);
               chk(dout_bad == 0, "R11 dout", dout_bad, 0);
               if (!w) chk(rd == ~wd, "R6 read data", rd, ~wd);
            end
         end
      end

      // R8 bus separate with command mode
      hostop(5'h14, 1, 8'h02, rd, cyc);
      hostop(5'h04, 1, 8'h99, rd, cyc);
      chk(nd_bsep_n == 1'b0, "R8 bsep on", int'(nd_bsep_n), 0);
      hostop(5'h04, 0, 0, rd, cyc); chk(rd == 8'h99, "R7 mode readback", rd, 8'h99);
      clr_mon(); exp_dout = 8'h70;
      hostop(5'h00, 1, 8'h70, rd, cyc);
      chk(cle_low == 3, "R8 cmd decode with bsep", cle_low, 3);

      // R9 set / clear, and R10 irq gating
      hostop(5'h08, 0, 0, rd, cyc); chk(rd == 0, "R9 status clear initially", rd, 0);
      nd_rdy = 1; repeat (5) @(negedge clk);
      hostop(5'h08, 0, 0, rd, cyc); chk(rd == 1, "R9 edge sets flag", rd, 1);
      chk(irq == 1'b1, "R10 irq with 0x81", int'(irq), 1);
      hostop(5'h10, 1, 8'h01, rd, cyc); chk(irq == 1'b0, "R10 irq mask 0x01", int'(irq), 0);
      hostop(5'h10, 1, 8'h80, rd, cyc); chk(irq == 1'b0, "R10 irq mask 0x80", int'(irq), 0);
      hostop(5'h10, 1, 8'h81, rd, cyc);
      hostop(5'h08, 1, 8'h00, rd, cyc);
      hostop(5'h08, 0, 0, rd, cyc); chk(rd == 1, "R9 write 0 keeps flag", rd, 1);
      hostop(5'h08, 1, 8'h01, rd, cyc);
      hostop(5'h08, 0, 0, rd, cyc); chk(rd == 0, "R9 write 1 clears", rd, 0);
      chk(irq == 1'b0, "R10 irq drops", int'(irq), 0);

      // R9 same-cycle race: clear one before, on, and one after the set edge
      nd_rdy = 0; repeat (5) @(negedge clk);
      nd_rdy = 1; repeat (5) @(negedge clk);
      for (int d = -1; d <= 1; d++) begin
         nd_rdy = 0; repeat (5) @(negedge clk);
         nd_rdy = 1;
         repeat (2 + d) @(negedge clk);
         hostop(5'h08, 1, 8'h01, rd, cyc);
         repeat (3) @(negedge clk);
         hostop(5'h08, 0, 0, rd, cyc);
         chk(rd == ((d <= 0) ? 1 : 0), "R9 set vs clear race", rd, (d <= 0) ? 1 : 0);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule